// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block chooses the divider settings of a clock synthesizer for a requested pixel frequency in kHz. The synthesizer produces `FREF*(n+2)/(m+2)` with integer division, and that result is shifted right by a post-divider exponent `k`. The engine walks every `(k, m)` pair and, for each one, derives an estimate of the feedback multiplier `n` from the target. It then tries only the two multipliers next to that estimate and keeps the candidate whose frequency lies closest to the request.

A request is issued by pulsing `start` while `freq_khz` carries the target. `freq_khz` must stay unchanged until `done` arrives. All quotients come from one shared restoring divider that needs 32 iterations per division. Each pair takes three divisions: one for the estimate and up to two for the candidates. When the sweep ends, the engine presents the packed control word and the frequency that word really produces, and pulses `done` for one cycle.

Top module: `pll_search`

## Requirements
- R1: After reset, `done`, `ctrl_word` and `freq_hit` are all zero.
- R2: The search visits `k` from `K_START` down to 0 in the outer loop and `m` from `M_START` down to 0 in the inner loop. Within a pair it tries the lower multiplier first. A candidate replaces the stored best only when its absolute error is strictly smaller, so on a tie the earlier candidate wins.
- R3: For each pair the quotient is `q = ((freq_khz*(m+2)) << k) / FREF`. The multipliers tried are `q-2` and `q-1`, each kept only if it lies in 0..255. This gives none, one or two candidates.
- R4: A candidate's frequency is `(FREF*(n+2)/(m+2)) >> k` with integer division, and its error is the absolute difference from `freq_khz`.
- R5: `ctrl_word` packs the winner as `n` in bits 15:8, `m` in bits 7:2 and `k` in bits 1:0.
- R6: `freq_hit` is the frequency of the winning candidate and equals the R4 formula applied to the fields of `ctrl_word`.
- R7: If no pair yields a candidate, `ctrl_word` and `freq_hit` are both zero.
- R8: `done` is high for exactly one cycle per accepted request. A `start` pulse that arrives while a search is running is ignored and does not change the result or the latency. A `start` pulse in the cycle of `done` is accepted.
- R9: The shared divider returns the exact floor quotient of its operands.
- R10: Within one search, the stored best error never grows. An accepted candidate's error becomes the new best.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| freq_khz | input | FREQ_W | Target frequency in kHz, stable during a search |
| done | output | 1 | One-cycle pulse when the result is valid |
| ctrl_word | output | 16 | Packed `{n, m, k}` of the best setting |
| freq_hit | output | DIV_W | Frequency in kHz produced by the best setting |

## Verification
Two events can coincide at the edge of the block: a new `start` and the completion of the previous search, and a stray `start` and a running search. The bench chains every request so that its `start` falls in the same cycle as the previous `done`. It judges each result against an arithmetic model of the sweep. One target is then run twice, the second time with an extra `start` pulse partway through. A matching result and an identical cycle count show that the stray pulse was ignored.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int N_W    = 8;
  localparam int M_W    = 6;
  localparam int K_W    = 2;
  localparam int WORD_W = N_W + M_W + K_W;
  localparam int N_MAX  = (1 << N_W) - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_EST_GO, S_EST_WAIT, S_CAND_GO, S_CAND_WAIT, S_STEP, S_FINISH
  } srch_state_e;

  typedef struct packed {
    logic           ok;
    logic [N_W-1:0] lo;
    logic [N_W-1:0] hi;
  } n_window_t;

  // multipliers q-2 and q-1, clipped to 0..N_MAX
  function automatic n_window_t n_window(input logic [63:0] q);
    n_window_t w;
    w = '0;
    if (q != 64'd0 && q <= 64'(N_MAX + 2)) begin
      w.ok = 1'b1;
      w.lo = (q < 64'd2) ? '0 : N_W'(q - 64'd2);
      w.hi = ((q - 64'd1) > 64'(N_MAX)) ? N_W'(N_MAX) : N_W'(q - 64'd1);
    end
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic [N_W-1:0] n,
                                                  input logic [M_W-1:0] m,
                                                  input logic [K_W-1:0] k);
    return {n, m, k};
  endfunction
endpackage

// File: rtl/pll_divider.sv
module pll_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         valid,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);
  localparam int DW = 2 * W;

  logic [CW-1:0] cnt;
  logic [W:0]    rem;
  logic [W-1:0]  dvs_q, dvd_q;
  logic [W:0]    shifted, trial;
  logic          fits;

  always_comb begin
    shifted = {rem[W-1:0], quotient[W-1]};
    fits    = shifted >= {1'b0, dvs_q};
    trial   = fits ? (shifted - {1'b0, dvs_q}) : shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rem      <= '0;
      quotient <= '0;
      dvs_q    <= '0;
      dvd_q    <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (start) begin
        cnt      <= CW'(W);
        rem      <= '0;
        quotient <= dividend;
        dvs_q    <= divisor;
        dvd_q    <= dividend;
      end else if (cnt != '0) begin
        cnt      <= cnt - 1'b1;
        rem      <= trial;
        quotient <= {quotient[W-2:0], fits};
        if (cnt == CW'(1)) valid <= 1'b1;
      end
    end
  end

  assign busy = (cnt != '0);

  // R9
  quot_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((DW'(quotient) * DW'(dvs_q) <= DW'(dvd_q)) &&
               (DW'(dvd_q) < (DW'(quotient) + DW'(1)) * DW'(dvs_q))));

  // R9
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dvs_q != '0) |-> (rem < {1'b0, dvs_q}));
endmodule

// File: rtl/pll_best_tracker.sv
module pll_best_tracker
  import pll_search_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              offer,
  input  logic [W-1:0]      cand_f,
  input  logic [WORD_W-1:0] cand_word,
  input  logic [W-1:0]      target,
  output logic [WORD_W-1:0] best_word,
  output logic [W-1:0]      best_f
);
  logic [W-1:0] best_err;
  logic [W-1:0] cand_err;
  logic         accept;

  assign cand_err = (cand_f >= target) ? (cand_f - target) : (target - cand_f);
  assign accept   = offer && (cand_err < best_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err  <= '1;
      best_word <= '0;
      best_f    <= '0;
    end else if (clear) begin
      best_err  <= '1;
      best_word <= '0;
      best_f    <= '0;
    end else if (accept) begin
      best_err  <= cand_err;
      best_word <= cand_word;
      best_f    <= cand_f;
    end
  end

  // R10
  best_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clear) |=> (best_err == $past(cand_err)));

  // R10
  best_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (best_err <= $past(best_err)));
endmodule

// File: rtl/pll_search.sv
module pll_search
  import pll_search_pkg::*;
#(
  parameter int FREF_KHZ = 14318,
  parameter int FREQ_W   = 20,
  parameter int DIV_W    = 32,
  parameter int M_START  = 63,
  parameter int K_START  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq_khz,
  output logic              done,
  output logic [15:0]       ctrl_word,
  output logic [DIV_W-1:0]  freq_hit
);
  localparam logic [M_W-1:0]   M_TOP = M_W'(M_START);
  localparam logic [K_W-1:0]   K_TOP = K_W'(K_START);
  localparam logic [DIV_W-1:0] FREF  = DIV_W'(FREF_KHZ);

  srch_state_e       state;
  logic [M_W-1:0]    m_idx;
  logic [K_W-1:0]    k_idx;
  logic [N_W-1:0]    cand_n, cand_hi;

  logic              accept_req, div_start, div_busy, div_valid, offer;
  logic [DIV_W-1:0]  div_dvd, div_dvs, div_quot, target, cand_f;
  logic [WORD_W-1:0] best_word, cand_word;
  logic [DIV_W-1:0]  best_f;
  n_window_t         win;

  assign accept_req = (state == S_IDLE) && start;
  assign target     = DIV_W'(freq_khz);
  assign div_start  = (state == S_EST_GO) || (state == S_CAND_GO);
  assign offer      = (state == S_CAND_WAIT) && div_valid;
  assign cand_f     = div_quot >> k_idx;
  assign cand_word  = pack_word(cand_n, m_idx, k_idx);
  assign win        = n_window(64'(div_quot));

  always_comb begin
    if (state == S_EST_GO) begin
      div_dvd = (target * (DIV_W'(m_idx) + DIV_W'(2))) << k_idx;
      div_dvs = FREF;
    end else begin
      div_dvd = FREF * (DIV_W'(cand_n) + DIV_W'(2));
      div_dvs = DIV_W'(m_idx) + DIV_W'(2);
    end
  end

  pll_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(div_dvd), .divisor(div_dvs),
    .busy(div_busy), .valid(div_valid), .quotient(div_quot)
  );

  pll_best_tracker #(.W(DIV_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clear(accept_req), .offer(offer),
    .cand_f(cand_f), .cand_word(cand_word), .target(target),
    .best_word(best_word), .best_f(best_f)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      m_idx     <= '0;
      k_idx     <= '0;
      cand_n    <= '0;
      cand_hi   <= '0;
      done      <= 1'b0;
      ctrl_word <= '0;
      freq_hit  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          m_idx <= M_TOP;
          k_idx <= K_TOP;
          state <= S_EST_GO;
        end
        S_EST_GO:  state <= S_EST_WAIT;
        S_EST_WAIT: if (div_valid) begin
          cand_n  <= win.lo;
          cand_hi <= win.hi;
          state   <= win.ok ? S_CAND_GO : S_STEP;
        end
        S_CAND_GO: state <= S_CAND_WAIT;
        S_CAND_WAIT: if (div_valid) begin
          if (cand_n < cand_hi) begin
            cand_n <= cand_n + 1'b1;
            state  <= S_CAND_GO;
          end else begin
            state  <= S_STEP;
          end
        end
        S_STEP: begin
          if (m_idx != '0) begin
            m_idx <= m_idx - 1'b1;
            state <= S_EST_GO;
          end else if (k_idx != '0) begin
            k_idx <= k_idx - 1'b1;
            m_idx <= M_TOP;
            state <= S_EST_GO;
          end else begin
            state <= S_FINISH;
          end
        end
        S_FINISH: begin
          done      <= 1'b1;
          ctrl_word <= 16'(best_word);
          freq_hit  <= best_f;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  div_idle_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !div_busy);

  // R5
  field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctrl_word[1:0] <= K_TOP && ctrl_word[7:2] <= M_TOP));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STEP && start) |=> (state != S_IDLE));
endmodule

// File: tb/test_pll_search.sv
module test_pll_search;
  localparam int CLK_PERIOD = 10;
  localparam int MS   = 7;
  localparam int KS   = 3;
  localparam int FREF = 14318;
  localparam int NV   = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] freq_khz = '0;
  logic        done;
  logic [15:0] ctrl_word;
  logic [31:0] freq_hit;

  int  n_vec = 0, n_bad = 0, cycles = 0;
  bit  timed_out = 1'b0;
  int  vec [NV];

  pll_search #(.FREF_KHZ(FREF), .M_START(MS), .K_START(KS)) i_pll_search (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq_khz),
    .done(done), .ctrl_word(ctrl_word), .freq_hit(freq_hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input longint f, output longint w, output longint fo);
    longint best;
    best = 64'h7fff_ffff_ffff_ffff;
    w = 0;
    fo = 0;
    for (int k = KS; k >= 0; k--) begin
      for (int m = MS; m >= 0; m--) begin
        longint q, lo, hi;
        q  = ((f * (m + 2)) << k) / FREF;
        lo = (q - 2 < 0) ? 0 : q - 2;
        hi = (q - 1 > 255) ? 255 : q - 1;
        for (longint n = lo; n <= hi; n++) begin
          longint fc, e;
          fc = ((FREF * (n + 2)) / (m + 2)) >> k;
          e  = (fc > f) ? fc - f : f - fc;
          if (e < best) begin
            best = e;
            w  = (n << 8) | (longint'(m) << 2) | longint'(k);
            fo = fc;
          end
        end
      end
    end
  endfunction

  function automatic longint decode_freq(input logic [15:0] w);
    longint n, m, k;
    n = longint'(w[15:8]);
    m = longint'(w[7:2]);
    k = longint'(w[1:0]);
    return ((FREF * (n + 2)) / (m + 2)) >> k;
  endfunction

  task automatic wait_done();
    while (!done && !timed_out) begin
      @(negedge clk);
      if (cycles > 190000) timed_out = 1'b1;
    end
  endtask

  task automatic judge(input int f);
    longint ew, ef;
    model(longint'(f), ew, ef);
    if (ew == 0 && ef == 0) begin
      check(ctrl_word == 16'd0, "R7 empty word", longint'(ctrl_word), 0);
      check(freq_hit == 32'd0, "R7 empty freq", longint'(freq_hit), 0);
    end else begin
      check(longint'(ctrl_word) == ew, "R2 R3 R9 R10 ctrl_word", longint'(ctrl_word), ew);
      check(longint'(freq_hit) == ef, "R4 R6 freq_hit", longint'(freq_hit), ef);
      check(decode_freq(ctrl_word) == longint'(freq_hit), "R5 field packing",
            decode_freq(ctrl_word), longint'(freq_hit));
    end
  endtask

  task automatic launch(input int f);
    freq_khz = 20'(f);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R8 single-cycle done", longint'(done), 0);
  endtask

  initial begin
    int t0, lat_plain, lat_poked;
    vec[0] = 0;
    vec[1] = 1;
    vec[2] = 100;
    vec[3] = 25175;
    for (int j = 0; j < 18; j++) vec[4 + j] = 20000 + j * 23000;
    vec[22] = 900000;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done", longint'(done), 0);
    check(ctrl_word == 16'd0, "R1 ctrl_word", longint'(ctrl_word), 0);
    check(freq_hit == 32'd0, "R1 freq_hit", longint'(freq_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // chained sweep: every new start lands in the done cycle (R8)
    launch(vec[0]);
    for (int i = 0; i < NV && !timed_out; i++) begin
      wait_done();
      if (timed_out) break;
      judge(vec[i]);
      if (i + 1 < NV) launch(vec[i + 1]);
    end

    // stray start during a search is ignored (R8)
    if (!timed_out) begin
      @(negedge clk);
      t0 = cycles;
      launch(65000);
      wait_done();
      lat_plain = cycles - t0;
      if (!timed_out) judge(65000);
      @(negedge clk);
      t0 = cycles;
      launch(65000);
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      lat_poked = cycles - t0;
      if (!timed_out) begin
        judge(65000);
        check(lat_poked == lat_plain, "R8 stray start latency",
              longint'(lat_poked), longint'(lat_plain));
        @(negedge clk);
        check(done == 1'b0, "R8 no second done", longint'(done), 0);
      end
    end

    if (timed_out) check(1'b0, "watchdog", longint'(cycles), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule